// File: doc/BRIEF.md
# Execute-Stage Jump Resolver

This block settles register-indirect jumps in the execute stage of a five-stage pipeline. Each cycle it captures the instruction leaving decode: its jump operation code, the target register value, the sequential (fall-through) address and the fetch-time prediction bit. It then combines them with the condition flags on the `ex_flags` input. Those flags are the forwarded values for the same cycle, so they are not registered. A conditional jump on zero, negative or carry is taken when its flag is set. An unconditional jump and a call are always taken. A taken conditional jump also asks the flag register to clear the flag it tested.

Fetch uses a static not-taken guess. Whenever the real outcome differs from the prediction bit, the block raises a flush for the younger instructions in fetch and decode, together with a redirect address. The redirect goes to the target when the jump is taken and to the sequential address when it is not. The instruction handed over from decode in that same cycle is already wrong-path. The capture stage therefore marks that slot as squashed, and it produces nothing in the following cycle.

The capture stage is a three-state slot machine:
- `SLOT_EMPTY`: no instruction is held.
- `SLOT_LIVE`: a valid instruction is held.
- `SLOT_SQUASHED`: a wrong-path instruction was dropped.

Every state follows the same transitions:
- It goes to `SLOT_SQUASHED` when flush is high.
- Otherwise it goes to `SLOT_LIVE` when `id_valid` is high.
- Otherwise it goes to `SLOT_EMPTY`.

Top module: `jump_resolver`

## Requirements
- R1: While reset is active and after it, before any instruction, the slot is `SLOT_EMPTY` and `jump_taken`, `flush`, `redirect_valid`, `redirect_pc` and `flag_clear` are all zero.
- R2: Operation code 1 (jump on zero) is taken exactly when `ex_flags[0]` (Z) is 1, and then redirects to the captured target.
- R3: Operation code 2 (jump on negative) is taken exactly when `ex_flags[1]` (N) is 1. Operation code 3 (jump on carry) is taken exactly when `ex_flags[2]` (C) is 1. Both redirect to the captured target.
- R4: Operation codes 4 (jump) and 5 (call) are taken whatever the flags are, and redirect to the captured target.
- R5: A taken conditional jump drives a one-hot `flag_clear` naming the tested flag (bit 0 Z, bit 1 N, bit 2 C). Codes 4 and 5 and not-taken jumps drive `flag_clear` to zero.
- R6: A jump predicted not-taken that is not taken produces no redirect, no flush and no flag clear.
- R7: `flush` and `redirect_valid` are high exactly when the outcome differs from the captured prediction bit. A taken jump that was predicted taken raises `jump_taken` without a flush.
- R8: A jump predicted taken that is not taken flushes and redirects to the captured sequential address.
- R9: The instruction presented on the `id_*` inputs in a cycle where `flush` is high is dropped. The next cycle shows no taken jump, flush or flag clear.
- R10: Operation codes 0, 6 and 7, and cycles with no valid instruction, produce all-zero outputs regardless of the flags.
- R11: The decision uses the `ex_flags` value present in the execute cycle itself. A flag change within that cycle changes the outcome without a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode hands over a valid instruction |
| id_op | input | 3 | Jump operation code (0 none, 1 Z, 2 N, 3 C, 4 jump, 5 call) |
| id_target | input | ADDR_W | Target register value |
| id_seq_pc | input | ADDR_W | Sequential address after the instruction |
| id_pred_taken | input | 1 | Prediction made at fetch |
| ex_flags | input | 3 | Forwarded flags for the execute cycle: bit 0 Z, bit 1 N, bit 2 C |
| jump_taken | output | 1 | The execute-stage jump is taken |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | ADDR_W | Corrected fetch address |
| flush | output | 1 | Discard younger instructions in fetch and decode |
| flag_clear | output | 3 | One-hot request to clear the tested flag |

## Verification
Each jump kind is driven with its tested flag set and then cleared, with the other flags set to the opposite values. A wrong flag bit or a missing one-hot clear mask therefore shows at once. Unconditional kinds run with all flags both low and high, and the unused codes run with every flag set, which separates decoding from flag sensing. Both prediction values are paired with both outcomes, which keeps flush generation apart from the taken signal and checks the choice between target and sequential redirect. Directed cases cover the squashed slot after a flush, a flag change within the execute cycle, and reset arriving while a jump is held.

// File: rtl/jmpres_pkg.sv
package jmpres_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_JZ   = 3'd1,
        OP_JN   = 3'd2,
        OP_JC   = 3'd3,
        OP_JMP  = 3'd4,
        OP_CALL = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } jop_e;

    localparam int NFLAGS = 3;
    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 2;

    typedef enum logic [1:0] {
        SLOT_EMPTY    = 2'd0,
        SLOT_LIVE     = 2'd1,
        SLOT_SQUASHED = 2'd2
    } slot_e;

endpackage

// File: rtl/jmpres_slot.sv
module jmpres_slot
    import jmpres_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [2:0]        id_op,
    input  logic [ADDR_W-1:0] id_target,
    input  logic [ADDR_W-1:0] id_seq_pc,
    input  logic              id_pred_taken,
    input  logic              kill,
    output logic              ex_live,
    output logic [2:0]        ex_op,
    output logic [ADDR_W-1:0] ex_target,
    output logic [ADDR_W-1:0] ex_seq_pc,
    output logic              ex_pred
);

    slot_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = SLOT_EMPTY;
        unique case (state_q)
            SLOT_EMPTY, SLOT_LIVE, SLOT_SQUASHED: begin
                if (kill)          state_d = SLOT_SQUASHED;
                else if (id_valid) state_d = SLOT_LIVE;
                else               state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // Payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_op     <= '0;
            ex_target <= '0;
            ex_seq_pc <= '0;
            ex_pred   <= 1'b0;
        end else begin
            ex_op     <= id_op;
            ex_target <= id_target;
            ex_seq_pc <= id_seq_pc;
            ex_pred   <= id_pred_taken;
        end
    end

    // Output process
    always_comb begin
        ex_live = 1'b0;
        unique case (state_q)
            SLOT_LIVE:                 ex_live = 1'b1;
            SLOT_EMPTY, SLOT_SQUASHED: ex_live = 1'b0;
            default:                   ex_live = 1'b0;
        endcase
    end

    AST_SQUASH_FOLLOWS_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (state_q == SLOT_SQUASHED)); // R9

endmodule

// File: rtl/jmpres_eval.sv
module jmpres_eval
    import jmpres_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              live,
    input  logic [2:0]        op,
    input  logic [NFLAGS-1:0] flags,
    input  logic              pred,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] seq_pc,
    output logic              taken,
    output logic              mispredict,
    output logic [NFLAGS-1:0] clear_mask,
    output logic [ADDR_W-1:0] redirect_pc
);

    logic is_jump;
    logic is_cond;
    logic cond_ok;
    logic [NFLAGS-1:0] test_sel;

    always_comb begin
        is_jump  = 1'b0;
        is_cond  = 1'b0;
        test_sel = '0;
        unique case (jop_e'(op))
            OP_JZ:   begin is_jump = 1'b1; is_cond = 1'b1; test_sel[FLAG_Z] = 1'b1; end
            OP_JN:   begin is_jump = 1'b1; is_cond = 1'b1; test_sel[FLAG_N] = 1'b1; end
            OP_JC:   begin is_jump = 1'b1; is_cond = 1'b1; test_sel[FLAG_C] = 1'b1; end
            OP_JMP,
            OP_CALL: begin is_jump = 1'b1; end
            OP_NONE,
            OP_RSV6,
            OP_RSV7: begin is_jump = 1'b0; end
            default: begin is_jump = 1'b0; end
        endcase
    end

    always_comb begin
        cond_ok     = is_cond ? |(flags & test_sel) : 1'b1;
        taken       = live && is_jump && cond_ok;
        mispredict  = live && is_jump && (taken != pred);
        clear_mask  = (taken && is_cond) ? test_sel : '0;
        redirect_pc = mispredict ? (taken ? target : seq_pc) : '0;
    end

endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
    import jmpres_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [2:0]        id_op,
    input  logic [ADDR_W-1:0] id_target,
    input  logic [ADDR_W-1:0] id_seq_pc,
    input  logic              id_pred_taken,
    input  logic [2:0]        ex_flags,
    output logic              jump_taken,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              flush,
    output logic [2:0]        flag_clear
);

    logic              ex_live;
    logic [2:0]        ex_op;
    logic [ADDR_W-1:0] ex_target;
    logic [ADDR_W-1:0] ex_seq_pc;
    logic              ex_pred;
    logic              mispredict;

    jmpres_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_valid      (id_valid),
        .id_op         (id_op),
        .id_target     (id_target),
        .id_seq_pc     (id_seq_pc),
        .id_pred_taken (id_pred_taken),
        .kill          (mispredict),
        .ex_live       (ex_live),
        .ex_op         (ex_op),
        .ex_target     (ex_target),
        .ex_seq_pc     (ex_seq_pc),
        .ex_pred       (ex_pred)
    );

    jmpres_eval #(.ADDR_W(ADDR_W)) u_eval (
        .live        (ex_live),
        .op          (ex_op),
        .flags       (ex_flags),
        .pred        (ex_pred),
        .target      (ex_target),
        .seq_pc      (ex_seq_pc),
        .taken       (jump_taken),
        .mispredict  (mispredict),
        .clear_mask  (flag_clear),
        .redirect_pc (redirect_pc)
    );

    assign flush          = mispredict;
    assign redirect_valid = mispredict;

    AST_CLEAR_ONEHOT:     assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clear)); // R5
    AST_CLEAR_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear != '0) |-> jump_taken); // R5
    AST_PRED_HIT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_taken && ex_pred) |-> !flush); // R7
    AST_SHADOW_QUIET:     assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!flush && !jump_taken)); // R9
    AST_IDLE_QUIET:       assert property (@(posedge clk) disable iff (!rst_n)
        !ex_live |-> (!jump_taken && !flush && flag_clear == '0)); // R10

endmodule

// File: tb/jump_resolver_tb_top.sv
module jump_resolver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int NVEC = 15;

    // {op[12:10], flags[9:7] (C,N,Z), pred[6], taken[5], flush[4], clear[3:1] (C,N,Z), seq_sel[0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {3'd1, 3'b001, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0}, // R2 jz taken
        {3'd1, 3'b110, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0}, // R2 R6 jz not taken
        {3'd2, 3'b010, 1'b0, 1'b1, 1'b1, 3'b010, 1'b0}, // R3 jn taken
        {3'd2, 3'b101, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0}, // R3 jn not taken
        {3'd3, 3'b100, 1'b0, 1'b1, 1'b1, 3'b100, 1'b0}, // R3 jc taken
        {3'd3, 3'b011, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0}, // R3 jc not taken
        {3'd4, 3'b000, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0}, // R4 R5 jmp
        {3'd5, 3'b111, 1'b0, 1'b1, 1'b1, 3'b000, 1'b0}, // R4 R5 call
        {3'd0, 3'b111, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0}, // R10 none
        {3'd6, 3'b111, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0}, // R10 code 6
        {3'd7, 3'b111, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0}, // R10 code 7
        {3'd1, 3'b001, 1'b1, 1'b1, 1'b0, 3'b001, 1'b0}, // R7 predicted hit
        {3'd1, 3'b110, 1'b1, 1'b0, 1'b1, 3'b000, 1'b1}, // R8 predicted miss
        {3'd4, 3'b000, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R7 jmp predicted
        {3'd5, 3'b000, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}  // R7 call predicted
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              id_valid;
    logic [2:0]        id_op;
    logic [ADDR_W-1:0] id_target;
    logic [ADDR_W-1:0] id_seq_pc;
    logic              id_pred_taken;
    logic [2:0]        ex_flags;
    logic              jump_taken;
    logic              redirect_valid;
    logic [ADDR_W-1:0] redirect_pc;
    logic              flush;
    logic [2:0]        flag_clear;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jump_resolver #(.ADDR_W(ADDR_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .id_valid       (id_valid),
        .id_op          (id_op),
        .id_target      (id_target),
        .id_seq_pc      (id_seq_pc),
        .id_pred_taken  (id_pred_taken),
        .ex_flags       (ex_flags),
        .jump_taken     (jump_taken),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .flush          (flush),
        .flag_clear     (flag_clear)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic present(input logic [2:0] op, input logic [2:0] fl, input logic pred,
                           input logic [31:0] tgt, input logic [31:0] seq);
        @(negedge clk);
        id_valid = 1'b1; id_op = op; id_target = tgt; id_seq_pc = seq;
        id_pred_taken = pred; ex_flags = fl;
        @(negedge clk);
        id_valid = 1'b0; id_op = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; id_valid = 1'b0; id_op = '0; id_target = '0;
        id_seq_pc = '0; id_pred_taken = 1'b0; ex_flags = 3'b111;
        repeat (3) @(negedge clk);
        chk("R1 reset taken", {31'd0, jump_taken}, 0);
        chk("R1 reset flush", {31'd0, flush}, 0);
        chk("R1 reset redirect", {31'd0, redirect_valid}, 0);
        chk("R1 reset pc", redirect_pc, 0);
        chk("R1 reset clear", {29'd0, flag_clear}, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            logic [31:0] tgt, seq;
            v   = VEC[i];
            tgt = 32'h1000_0000 + i;
            seq = 32'h2000_0000 + i;
            present(v[12:10], v[9:7], v[6], tgt, seq);
            chk($sformatf("R2-7 vec%0d taken", i), {31'd0, jump_taken}, {31'd0, v[5]});
            chk($sformatf("R7 vec%0d flush", i), {31'd0, flush}, {31'd0, v[4]});
            chk($sformatf("R7 vec%0d redirect", i), {31'd0, redirect_valid}, {31'd0, v[4]});
            chk($sformatf("R5 vec%0d clear", i), {29'd0, flag_clear}, {29'd0, v[3:1]});
            if (v[4]) chk($sformatf("R8 vec%0d pc", i), redirect_pc, v[0] ? seq : tgt);
            @(negedge clk);
        end

        // R9: instruction arriving during a flush is dropped
        @(negedge clk);
        id_valid = 1'b1; id_op = 3'd4; id_target = 32'hAAAA_0000;
        id_seq_pc = 32'h1; id_pred_taken = 1'b0; ex_flags = 3'b001;
        @(negedge clk);
        chk("R9 flush on jmp", {31'd0, flush}, 1);
        id_op = 3'd1; id_target = 32'hBBBB_0000;
        @(negedge clk);
        id_valid = 1'b0; id_op = '0;
        chk("R9 shadow taken", {31'd0, jump_taken}, 0);
        chk("R9 shadow flush", {31'd0, flush}, 0);
        chk("R9 shadow clear", {29'd0, flag_clear}, 0);
        @(negedge clk);

        // R11: same-cycle flag change
        present(3'd2, 3'b000, 1'b0, 32'hCCCC_0000, 32'h2);
        chk("R11 N low", {31'd0, jump_taken}, 0);
        #1 ex_flags = 3'b010;
        #1 chk("R11 N raised", {31'd0, jump_taken}, 1);
        chk("R11 clear", {29'd0, flag_clear}, 3'b010);
        chk("R11 pc", redirect_pc, 32'hCCCC_0000);
        @(negedge clk);

        // R10: no valid instruction with flags set
        ex_flags = 3'b111;
        @(negedge clk);
        chk("R10 idle", {30'd0, jump_taken, flush}, 0);

        // R1: reset while a jump is held
        present(3'd4, 3'b000, 1'b0, 32'hDDDD_0000, 32'h3);
        chk("R4 before reset", {31'd0, jump_taken}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset", {30'd0, jump_taken, flush}, 0);
        chk("R1 mid reset pc", redirect_pc, 0);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule